// File: doc/BRIEF.md
# DS3 Maintenance Signal Detector

This block watches the content of a demultiplexed DS3 frame and raises four status flags. Two flags report the alarm indication payload and the idle payload. One reports C bits that stay at zero. One reports the remote alarm indication carried on the X bits. Each flag uses separate rules to set and to clear, so a noisy line does not make it toggle. Combining the flags into a final alarm decision is left to logic outside the block.

The upstream framer supplies three kinds of input:
- information bits, each with a valid strobe;
- C bits, each tagged with its subframe index (0..6) and its position in the subframe (0..2);
- X bits, each with a valid strobe.

A frame-start strobe marks each frame boundary. That strobe closes the frame collected since the previous strobe and opens a new one. Any bit that is valid in the same cycle as the strobe belongs to the new frame. The first strobe after reset only opens a frame.

The payload checks tolerate bit errors. For each payload type, the block compares the incoming bits against all four rotations of the pattern at the same time. It scores the frame by the best-matching rotation, so it needs no phase search.

Top module: `ds3_maint_det`

## Requirements
- R1: After reset, all four flags (`ais_o`, `idle_o`, `cbz_o`, `rai_o`) are 0. A frame-start strobe that only opens a frame changes none of them.
- R2: Apart from the C-bit-zero clear in R8, a flag changes only on the clock edge that samples a frame-start strobe closing an open frame. Bits received inside a frame do not move a flag before that edge.
- R3: `ais_o` sets when two consecutive closed frames each have fewer than 5 errors against the best rotation of the repeating information-bit pattern 1,0,1,0. A frame with exactly 5 errors does not qualify.
- R4: `idle_o` sets when two consecutive closed frames each have fewer than 5 errors against the best rotation of the repeating pattern 1,1,0,0.
- R5: A set payload flag clears only after two consecutive closed frames with at least 16 errors each. A single such frame, or frames with 5 to 15 errors, leave the flag set.
- R6: The per-rotation error counts saturate at 16 and never wrap. For example, a frame with 32 errors on every rotation still counts as a bad frame.
- R7: `cbz_o` sets when three consecutive closed frames each carry at least one C bit and all of their C bits are 0.
- R8: `cbz_o` clears on the edge that samples a position-2 C bit of value 1, when positions 0 and 1 of the same subframe index were also 1. Ones spread over different subframes do not clear it.
- R9: `rai_o` sets when two consecutive closed frames carry X bits that are all 0.
- R10: `rai_o` clears only when two consecutive closed frames carry X bits that are all 1. A frame with mixed X bits breaks either run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame boundary strobe: closes the open frame and opens the next |
| info_bit_i | input | 1 | Information bit |
| info_vld_i | input | 1 | Information bit valid |
| cbit_i | input | 1 | C bit value |
| cbit_vld_i | input | 1 | C bit valid |
| cbit_sub_i | input | 3 | Subframe index of the C bit, 0..6 |
| cbit_pos_i | input | 2 | Position of the C bit in its subframe, 0..2 |
| xbit_i | input | 1 | X bit value |
| xbit_vld_i | input | 1 | X bit valid |
| ais_o | output | 1 | Alarm indication payload detected |
| idle_o | output | 1 | Idle payload detected |
| cbz_o | output | 1 | C bits all zero |
| rai_o | output | 1 | Remote alarm indication |

## Verification
The payload, C-bit-zero set and RAI results appear on the edge that samples the closing frame-start strobe, one register stage after it. The bench pulses the strobe for one cycle and reads all four flags at the next falling edge. The C-bit-zero clear appears one edge after the position-2 C bit. The bench reads it after the frame's last X bit, before the next strobe. That same point also confirms that no other flag has moved inside the frame.

// File: rtl/ds3_maint_pkg.sv
package ds3_maint_pkg;
  localparam int unsigned PAT_LEN    = 4;
  localparam int unsigned N_SUB      = 7;
  localparam int unsigned SUB_W      = 3;
  localparam logic [3:0]  AIS_WORD   = 4'b1010;
  localparam logic [3:0]  IDLE_WORD  = 4'b1100;
  localparam int unsigned N_PAT      = 2;
  localparam int unsigned PAT_AIS    = 0;
  localparam int unsigned PAT_IDLE   = 1;

  typedef enum logic [1:0] {
    CPOS_FIRST  = 2'd0,
    CPOS_SECOND = 2'd1,
    CPOS_THIRD  = 2'd2
  } cpos_e;
endpackage

// File: rtl/ds3_pat_det.sv
module ds3_pat_det
  import ds3_maint_pkg::*;
#(
  parameter logic [3:0]  PATTERN   = AIS_WORD,
  parameter int unsigned SET_LIMIT = 5,
  parameter int unsigned CLR_LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic close_i,
  input  logic bit_i,
  input  logic bit_vld_i,
  output logic det_o
);
  localparam int unsigned CNT_W = $clog2(CLR_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLR_LIMIT);
  localparam logic [CNT_W-1:0] SET_CMP = CNT_W'(SET_LIMIT);

  logic [1:0]       phase_q, phase_eff;
  logic [CNT_W-1:0] cnt_q [PAT_LEN];
  logic [CNT_W-1:0] min_err;
  logic             prev_good_q, prev_bad_q, det_q;
  logic             frame_good, frame_bad;

  // a bit seen with the strobe is phase 0 of the new frame
  assign phase_eff = start_i ? 2'd0 : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (start_i) phase_q <= bit_vld_i ? 2'd1 : 2'd0;
    else if (bit_vld_i) phase_q <= phase_q + 2'd1;
  end

  for (genvar r = 0; r < PAT_LEN; r++) begin : g_rot
    logic [1:0] idx;
    logic       mis;
    assign idx = phase_eff + 2'(r);
    assign mis = bit_vld_i & (bit_i != PATTERN[2'd3 - idx]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[r] <= '0;
      else if (start_i) cnt_q[r] <= CNT_W'(mis);
      else if (mis && cnt_q[r] != CNT_MAX) cnt_q[r] <= cnt_q[r] + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[r] <= CNT_MAX); // R6
  end

  always_comb begin
    min_err = cnt_q[0];
    for (int r = 1; r < PAT_LEN; r++)
      if (cnt_q[r] < min_err) min_err = cnt_q[r];
  end

  assign frame_good = min_err < SET_CMP;
  assign frame_bad  = min_err >= CNT_MAX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_good_q <= 1'b0;
      prev_bad_q  <= 1'b0;
      det_q       <= 1'b0;
    end else if (close_i) begin
      prev_good_q <= frame_good;
      prev_bad_q  <= frame_bad;
      if (!det_q && frame_good && prev_good_q) det_q <= 1'b1;
      else if (det_q && frame_bad && prev_bad_q) det_q <= 1'b0;
    end
  end

  assign det_o = det_q;

  AST_PAT_RISE_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_q) |-> $past(close_i)); // R2
  AST_PAT_RISE_TWO_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_q) |-> $past(prev_good_q) && prev_good_q); // R3
  AST_PAT_FALL_TWO_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(det_q) |-> $past(close_i && prev_bad_q) && prev_bad_q); // R5
endmodule

// File: rtl/ds3_cbz_det.sv
module ds3_cbz_det
  import ds3_maint_pkg::*;
#(
  parameter int unsigned ZERO_FRAMES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             close_i,
  input  logic             cbit_i,
  input  logic             cbit_vld_i,
  input  logic [SUB_W-1:0] cbit_sub_i,
  input  logic [1:0]       cbit_pos_i,
  output logic             cbz_o
);
  localparam int unsigned RUN_W = $clog2(ZERO_FRAMES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ZERO_FRAMES);

  logic [1:0]       ones_q [N_SUB];
  logic             zero_q, seen_q, flag_q;
  logic [RUN_W-1:0] run_q, run_n;
  logic             sub_ok, clr_hit, frame_zero;

  assign sub_ok = 32'(cbit_sub_i) < N_SUB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SUB; s++) ones_q[s] <= '0;
    end else if (cbit_vld_i && sub_ok) begin
      if (cbit_pos_i == CPOS_FIRST)  ones_q[cbit_sub_i][0] <= cbit_i;
      if (cbit_pos_i == CPOS_SECOND) ones_q[cbit_sub_i][1] <= cbit_i;
    end
  end

  assign clr_hit = cbit_vld_i && sub_ok && cbit_i && cbit_pos_i == CPOS_THIRD
                   && (&ones_q[sub_ok ? cbit_sub_i : '0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q <= 1'b1;
      seen_q <= 1'b0;
    end else if (start_i) begin
      zero_q <= !(cbit_vld_i && cbit_i);
      seen_q <= cbit_vld_i;
    end else if (cbit_vld_i) begin
      zero_q <= zero_q & ~cbit_i;
      seen_q <= 1'b1;
    end
  end

  assign frame_zero = zero_q & seen_q;
  assign run_n = !frame_zero ? '0 : (run_q == RUN_MAX ? run_q : run_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (close_i) run_q <= run_n;
  end

  // clear wins over a set in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (clr_hit) flag_q <= 1'b0;
    else if (close_i && run_n == RUN_MAX) flag_q <= 1'b1;
  end

  assign cbz_o = flag_q;

  AST_CBZ_RISE_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(close_i) && run_q == RUN_MAX); // R7
  AST_CBZ_FALL_ON_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(cbit_vld_i && cbit_i && cbit_pos_i == CPOS_THIRD)); // R8
  AST_CBZ_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_MAX); // R7
endmodule

// File: rtl/ds3_rai_det.sv
module ds3_rai_det #(
  parameter int unsigned RUN_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic close_i,
  input  logic xbit_i,
  input  logic xbit_vld_i,
  output logic rai_o
);
  localparam int unsigned RUN_W = $clog2(RUN_FRAMES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_FRAMES);

  logic             all0_q, all1_q, seen_q, flag_q;
  logic             f_zero, f_one;
  logic [RUN_W-1:0] run0_q, run1_q, run0_n, run1_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all0_q <= 1'b1;
      all1_q <= 1'b1;
      seen_q <= 1'b0;
    end else if (start_i) begin
      all0_q <= !(xbit_vld_i && xbit_i);
      all1_q <= !(xbit_vld_i && !xbit_i);
      seen_q <= xbit_vld_i;
    end else if (xbit_vld_i) begin
      all0_q <= all0_q & ~xbit_i;
      all1_q <= all1_q & xbit_i;
      seen_q <= 1'b1;
    end
  end

  assign f_zero = seen_q & all0_q;
  assign f_one  = seen_q & all1_q;
  assign run0_n = !f_zero ? '0 : (run0_q == RUN_MAX ? run0_q : run0_q + 1'b1);
  assign run1_n = !f_one  ? '0 : (run1_q == RUN_MAX ? run1_q : run1_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run0_q <= '0;
      run1_q <= '0;
      flag_q <= 1'b0;
    end else if (close_i) begin
      run0_q <= run0_n;
      run1_q <= run1_n;
      if (!flag_q && run0_n == RUN_MAX) flag_q <= 1'b1;
      else if (flag_q && run1_n == RUN_MAX) flag_q <= 1'b0;
    end
  end

  assign rai_o = flag_q;

  AST_RAI_RISE_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(close_i) && run0_q == RUN_MAX); // R9
  AST_RAI_FALL_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(close_i) && run1_q == RUN_MAX); // R10
  AST_RAI_RUNS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run0_q != '0 && run1_q != '0)); // R10
endmodule

// File: rtl/ds3_maint_det.sv
module ds3_maint_det
  import ds3_maint_pkg::*;
#(
  parameter int unsigned SET_LIMIT   = 5,
  parameter int unsigned CLR_LIMIT   = 16,
  parameter int unsigned ZERO_FRAMES = 3,
  parameter int unsigned RAI_FRAMES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             info_bit_i,
  input  logic             info_vld_i,
  input  logic             cbit_i,
  input  logic             cbit_vld_i,
  input  logic [SUB_W-1:0] cbit_sub_i,
  input  logic [1:0]       cbit_pos_i,
  input  logic             xbit_i,
  input  logic             xbit_vld_i,
  output logic             ais_o,
  output logic             idle_o,
  output logic             cbz_o,
  output logic             rai_o
);
  localparam logic [3:0] PAT_TAB [N_PAT] = '{AIS_WORD, IDLE_WORD};

  logic             open_q, close;
  logic [N_PAT-1:0] pat_det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else if (frame_start_i) open_q <= 1'b1;
  end

  assign close = frame_start_i & open_q;

  for (genvar g = 0; g < N_PAT; g++) begin : g_pat
    ds3_pat_det #(
      .PATTERN  (PAT_TAB[g]),
      .SET_LIMIT(SET_LIMIT),
      .CLR_LIMIT(CLR_LIMIT)
    ) u_pat (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (frame_start_i),
      .close_i  (close),
      .bit_i    (info_bit_i),
      .bit_vld_i(info_vld_i),
      .det_o    (pat_det[g])
    );
  end

  ds3_cbz_det #(.ZERO_FRAMES(ZERO_FRAMES)) u_cbz (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (frame_start_i),
    .close_i   (close),
    .cbit_i    (cbit_i),
    .cbit_vld_i(cbit_vld_i),
    .cbit_sub_i(cbit_sub_i),
    .cbit_pos_i(cbit_pos_i),
    .cbz_o     (cbz_o)
  );

  ds3_rai_det #(.RUN_FRAMES(RAI_FRAMES)) u_rai (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (frame_start_i),
    .close_i   (close),
    .xbit_i    (xbit_i),
    .xbit_vld_i(xbit_vld_i),
    .rai_o     (rai_o)
  );

  assign ais_o  = pat_det[PAT_AIS];
  assign idle_o = pat_det[PAT_IDLE];

  AST_OPEN_BEFORE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ais_o || idle_o || cbz_o || rai_o) |-> open_q); // R1
endmodule

// File: tb/ds3_maint_det_bench.sv
module ds3_maint_det_bench;
  localparam int NBITS = 64;
  localparam logic [3:0] AIS  = 4'b1010;
  localparam logic [3:0] IDLE = 4'b1100;
  localparam logic [20:0] C_ZERO   = '0;
  localparam logic [20:0] C_ONE    = 21'h100000;            // k20 set
  localparam logic [20:0] C_SPREAD = 21'h000023;            // k0,k1 (sub0) and k5 (sub1 pos2)
  localparam logic [20:0] C_SUB4   = 21'h007000;            // k12..k14: all of sub4

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, info_bit = 0, info_vld = 0;
  logic cbit = 0, cbit_vld = 0, xbit = 0, xbit_vld = 0;
  logic [2:0] cbit_sub = '0;
  logic [1:0] cbit_pos = '0;
  logic ais, idle, cbz, rai;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ds3_maint_det u_ds3_maint_det (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start),
    .info_bit_i(info_bit), .info_vld_i(info_vld),
    .cbit_i(cbit), .cbit_vld_i(cbit_vld), .cbit_sub_i(cbit_sub), .cbit_pos_i(cbit_pos),
    .xbit_i(xbit), .xbit_vld_i(xbit_vld),
    .ais_o(ais), .idle_o(idle), .cbz_o(cbz), .rai_o(rai)
  );

  task automatic chk(input logic act, input logic exp, input string rq, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", rq, what, act, exp);
    end
  endtask

  task automatic chk4(input logic ea, input logic ei, input logic ec, input logic er,
                      input string tag);
    chk(ais,  ea, tag, "ais_o");
    chk(idle, ei, tag, "idle_o");
    chk(cbz,  ec, tag, "cbz_o");
    chk(rai,  er, tag, "rai_o");
  endtask

  task automatic boundary();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  // payload with nerr leading bits flipped, 21 C bits, 2 X bits
  task automatic send_frame(input logic [3:0] pat, input int rot, input int nerr,
                            input logic [20:0] cv, input logic [1:0] xv);
    for (int i = 0; i < NBITS; i++) begin
      @(negedge clk);
      info_vld = 1'b1;
      info_bit = pat[3 - ((i + rot) % 4)] ^ logic'(i < nerr);
    end
    for (int k = 0; k < 21; k++) begin
      @(negedge clk);
      info_vld = 1'b0;
      cbit_vld = 1'b1;
      cbit_sub = 3'(k / 3);
      cbit_pos = 2'(k % 3);
      cbit     = cv[k];
    end
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      cbit_vld = 1'b0;
      xbit_vld = 1'b1;
      xbit     = xv[j];
    end
    @(negedge clk) xbit_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk4(0, 0, 0, 0, "R1 reset");
    rst_n = 1'b1;
    boundary();
    chk4(0, 0, 0, 0, "R1 open only");

    send_frame(AIS, 1, 4, C_ZERO, 2'b00); boundary();      // F1
    chk4(0, 0, 0, 0, "R3/R9 one frame");
    send_frame(AIS, 1, 4, C_ZERO, 2'b00);                  // F2
    chk(ais, 0, "R2", "ais_o mid-frame");
    chk(rai, 0, "R2", "rai_o mid-frame");
    boundary();
    chk4(1, 0, 0, 1, "R3/R9 two frames");
    send_frame(AIS, 1, 4, C_ZERO, 2'b00); boundary();      // F3
    chk4(1, 0, 1, 1, "R7 three zero frames");

    send_frame(AIS, 3, 15, C_SPREAD, 2'b11);               // F4
    chk(cbz, 1, "R8", "cbz_o spread ones");
    boundary();
    chk4(1, 0, 1, 1, "R5 15 errors hold");
    send_frame(AIS, 0, 16, C_SUB4, 2'b01);                 // F5
    chk(cbz, 0, "R8", "cbz_o subframe ones");
    boundary();
    chk4(1, 0, 0, 1, "R5 one bad frame");
    send_frame(AIS, 2, 20, C_ONE, 2'b11); boundary();      // F6
    chk4(0, 0, 0, 1, "R5/R10 two bad frames, mixed run");
    send_frame(AIS, 0, 0, C_ONE, 2'b11); boundary();       // F7
    chk4(0, 0, 0, 0, "R10 two one frames");
    send_frame(AIS, 0, 5, C_ONE, 2'b00); boundary();       // F8
    chk4(0, 0, 0, 0, "R3 five errors");
    send_frame(AIS, 0, 4, C_ONE, 2'b10); boundary();       // F9
    chk4(0, 0, 0, 0, "R3 prior not good");
    send_frame(AIS, 2, 4, C_ONE, 2'b00); boundary();       // F10
    chk4(1, 0, 0, 0, "R3 rotation two");

    send_frame(IDLE, 2, 0, C_ZERO, 2'b00); boundary();     // F11
    chk4(1, 0, 0, 1, "R4/R9 first idle frame");
    send_frame(IDLE, 2, 2, C_ZERO, 2'b00); boundary();     // F12
    chk4(0, 1, 0, 1, "R4/R6 idle set, 32 errors clear");
    send_frame(IDLE, 1, 3, C_ZERO, 2'b00); boundary();     // F13
    chk4(0, 1, 1, 1, "R7 rerun after clear");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule